// File: doc/BRIEF.md
# Coherent DMA Request Controller

This block connects a DMA engine to a directory-based coherence fabric. The engine hands it one single-block load or store at a time; the controller forwards it to a fixed home directory as a DMA read or DMA write request, then follows the replies that come back. Each reply carries a signed acknowledgement adjustment, and an internal counter tracks how many replies are still owed. Data replies also deliver the block being read.

When the counter reaches zero, the controller queues an internal completion event in a one-entry trigger slot. Processing that event does four things: it reports completion to the engine (with the captured block for a load), schedules an exclusive-unblock message to the directory, releases the transaction and returns to idle. A second request offered while a transaction is open is held off until the controller is idle again. Forwarded requests from the network and malformed replies are protocol violations that set a sticky error flag.

The delay before the outgoing request and the delay before the unblock are fixed parameters. Each is realised as a small down-counter. The outgoing request and the unblock are single-cycle pulses whose payload is valid only during the pulse.

Top module: `dma_coh_ctrl`

## Requirements
- R1: After reset the controller is idle: seq_ready is 1, and req_valid, unb_valid, done_valid and err_flag are 0.
- R2: In idle, a request with seq_is_store=0 is taken at the clock edge where seq_valid and seq_ready are both 1. seq_ready is 0 from the next cycle on. REQ_LAT edges after the accepting edge, req_valid is 1 for one cycle, with req_is_write=0, the accepted address and length, and req_src=REQ_ID.
- R3: A request with seq_is_store=1 is handled the same way, except that the outgoing request has req_is_write=1 and carries the accepted data block on req_data.
- R4: Reply kinds are encoded on rsp_kind as 00 data, 01 invalidation ack and 10 write done. The pending counter starts at 0 and each legal reply subtracts its signed rsp_acks value from it. A reply that leaves the counter non-zero completes nothing.
- R5: During a load, a data reply stores its rsp_data block. On completion, done_is_read is 1 and done_data equals the stored block.
- R6: During a store, a write-done reply with a negative rsp_acks raises the counter. Later invalidation acks lower it. On completion, done_is_read is 0 and done_data is 0.
- R7: If a reply sets the counter to zero at edge E, then done_valid is 1 for exactly one cycle after edge E+1. In that same cycle seq_ready is already 1.
- R8: The trigger slot has priority over replies: in the cycle after a reply that zeroes the counter, rsp_ready is 0.
- R9: RSP_LAT edges after the completion edge, unb_valid is 1 for one cycle, with unb_addr equal to the completed transaction's address.
- R10: A request offered while a transaction is open is not taken: seq_ready stays 0 and no second outgoing request appears. The held request is taken at the first edge after completion.
- R11: A forwarded network request (net_fwd_valid=1) sets err_flag at the next edge. err_flag then stays 1 until reset.
- R12: These replies set err_flag, leave the counter unchanged and complete nothing: rsp_kind 11, any reply while idle, a data reply during a store, and a write-done reply during a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seq_valid | input | 1 | Engine request present |
| seq_ready | output | 1 | Request taken at this edge (idle) |
| seq_is_store | input | 1 | 1 = store, 0 = load |
| seq_addr | input | ADDR_W | Physical address |
| seq_len | input | LEN_W | Byte length |
| seq_data | input | DATA_W | Store data block |
| req_valid | output | 1 | One-cycle outgoing directory request |
| req_is_write | output | 1 | 1 = DMA write, 0 = DMA read |
| req_addr | output | ADDR_W | Request address |
| req_len | output | LEN_W | Request byte length |
| req_data | output | DATA_W | Request data block |
| req_src | output | ID_W | Requestor identity |
| rsp_valid | input | 1 | Directory reply present |
| rsp_ready | output | 1 | Reply consumed at this edge |
| rsp_kind | input | 2 | Reply kind |
| rsp_acks | input | ACK_W | Signed ack adjustment |
| rsp_data | input | DATA_W | Reply data block |
| unb_valid | output | 1 | One-cycle exclusive-unblock to the directory |
| unb_addr | output | ADDR_W | Unblock address |
| done_valid | output | 1 | One-cycle completion to the engine |
| done_is_read | output | 1 | Completion belongs to a load |
| done_data | output | DATA_W | Block read by a load |
| net_fwd_valid | input | 1 | Forwarded request from the network (illegal) |
| err_flag | output | 1 | Sticky protocol error |

## Verification
A counter that is off by one, or has the wrong sign, shows up as a missing or early done_valid. This appears one edge after the trigger would have been queued: either the completion never arrives, or it arrives while a sharer ack is still outstanding. A lost or stuck trigger slot shows in the same cycle as a wrong rsp_ready, and one cycle later as a missing done_valid. A wrong state shows as seq_ready accepting while busy, or as the wrong done_is_read at completion. The error flag and the stall are visible within one edge of the offending input.

// File: rtl/dma_coh_pkg.sv
package dma_coh_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_RD   = 2'b01,
      ST_WR   = 2'b10
   } dcc_state_e;

   localparam logic [1:0] RSP_DATA  = 2'b00;
   localparam logic [1:0] RSP_INV   = 2'b01;
   localparam logic [1:0] RSP_WDONE = 2'b10;

   typedef struct packed {
      logic upd;
      logic cap;
      logic err;
   } dcc_rsp_evt_t;

endpackage

// File: rtl/dcc_rsp_decode.sv
module dcc_rsp_decode
   import dma_coh_pkg::*;
(
   input  dcc_state_e   state,
   input  logic         fire,
   input  logic [1:0]   kind,
   output dcc_rsp_evt_t evt
);

   logic bad;

   always_comb begin
      bad = 1'b0;
      case (kind)
         RSP_DATA:  bad = (state != ST_RD);
         RSP_INV:   bad = (state == ST_IDLE);
         RSP_WDONE: bad = (state != ST_WR);
         default:   bad = 1'b1;
      endcase
      evt.err = fire && bad;
      evt.upd = fire && !bad;
      evt.cap = fire && !bad && (kind == RSP_DATA);
   end

endmodule

// File: rtl/dcc_ack_tracker.sv
module dcc_ack_tracker #(
   parameter int ACK_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clear,
   input  logic                    upd,
   input  logic signed [ACK_W-1:0] acks,
   input  logic                    consume,
   output logic                    trig_valid
);

   logic signed [ACK_W-1:0] cnt_q;
   logic signed [ACK_W-1:0] cnt_nxt;

   assign cnt_nxt = cnt_q - acks;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         trig_valid <= 1'b0;
      end else begin
         if (consume) trig_valid <= 1'b0;
         if (clear) begin
            cnt_q <= '0;
         end else if (upd) begin
            cnt_q <= cnt_nxt;
            if (cnt_nxt == '0) trig_valid <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/dcc_delay_pulse.sv
module dcc_delay_pulse #(
   parameter int MAX_LAT = 15,
   parameter int LAT     = 0,
   parameter int W       = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         fire,
   input  logic [W-1:0] din,
   output logic         pulse,
   output logic [W-1:0] dout
);

   localparam int CW = (MAX_LAT < 1) ? 1 : $clog2(MAX_LAT + 1);

   always_ff @(posedge clk) begin
      if (!rst_n) dout <= '0;
      else if (fire) dout <= din;
   end

   generate
      if (LAT == 0) begin : g_direct
         always_ff @(posedge clk) begin
            if (!rst_n) pulse <= 1'b0;
            else        pulse <= fire;
         end
      end else begin : g_counted
         localparam logic [CW-1:0] LAT_C = CW'(LAT);
         logic [CW-1:0] cnt_q;
         logic          act_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q <= '0;
               act_q <= 1'b0;
               pulse <= 1'b0;
            end else begin
               pulse <= 1'b0;
               if (fire) begin
                  cnt_q <= LAT_C;
                  act_q <= 1'b1;
               end else if (act_q) begin
                  cnt_q <= cnt_q - 1'b1;
                  if (cnt_q == CW'(1)) begin
                     pulse <= 1'b1;
                     act_q <= 1'b0;
                  end
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/dma_coh_ctrl.sv
module dma_coh_ctrl
   import dma_coh_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int LEN_W   = 8,
   parameter int DATA_W  = 64,
   parameter int ID_W    = 4,
   parameter int REQ_ID  = 1,
   parameter int ACK_W   = 8,
   parameter int MAX_LAT = 15,
   parameter int REQ_LAT = 2,
   parameter int RSP_LAT = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    seq_valid,
   output logic                    seq_ready,
   input  logic                    seq_is_store,
   input  logic [ADDR_W-1:0]       seq_addr,
   input  logic [LEN_W-1:0]        seq_len,
   input  logic [DATA_W-1:0]       seq_data,
   output logic                    req_valid,
   output logic                    req_is_write,
   output logic [ADDR_W-1:0]       req_addr,
   output logic [LEN_W-1:0]        req_len,
   output logic [DATA_W-1:0]       req_data,
   output logic [ID_W-1:0]         req_src,
   input  logic                    rsp_valid,
   output logic                    rsp_ready,
   input  logic [1:0]              rsp_kind,
   input  logic signed [ACK_W-1:0] rsp_acks,
   input  logic [DATA_W-1:0]       rsp_data,
   output logic                    unb_valid,
   output logic [ADDR_W-1:0]       unb_addr,
   output logic                    done_valid,
   output logic                    done_is_read,
   output logic [DATA_W-1:0]       done_data,
   input  logic                    net_fwd_valid,
   output logic                    err_flag
);

   localparam int REQ_PW = 1 + ADDR_W + LEN_W + DATA_W;

   generate
      if (ACK_W < 2) begin : g_bad_ack_w
         $error("ACK_W must be at least 2");
      end
      if (REQ_LAT < 0 || REQ_LAT > MAX_LAT) begin : g_bad_req_lat
         $error("REQ_LAT out of range");
      end
      if (RSP_LAT < 0 || RSP_LAT > MAX_LAT) begin : g_bad_rsp_lat
         $error("RSP_LAT out of range");
      end
      if (REQ_ID < 0 || REQ_ID >= (1 << ID_W)) begin : g_bad_id
         $error("REQ_ID does not fit ID_W");
      end
   endgenerate

   dcc_state_e        state_q;
   dcc_state_e        state_d;
   dcc_rsp_evt_t      evt;
   logic              seq_fire;
   logic              rsp_fire;
   logic              trig_valid;
   logic              trig_take;
   logic [ADDR_W-1:0] ent_addr_q;
   logic [DATA_W-1:0] ent_data_q;
   logic [REQ_PW-1:0] req_din;
   logic [REQ_PW-1:0] req_dout;

   assign seq_ready = (state_q == ST_IDLE);
   assign seq_fire  = seq_valid && seq_ready;
   assign rsp_ready = !trig_valid;
   assign rsp_fire  = rsp_valid && rsp_ready;
   assign trig_take = trig_valid && (state_q != ST_IDLE);
   assign req_src   = ID_W'(REQ_ID);

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE: if (seq_fire) state_d = seq_is_store ? ST_WR : ST_RD;
         ST_RD,
         ST_WR:   if (trig_take) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_addr_q <= '0;
         ent_data_q <= '0;
      end else if (seq_fire) begin
         ent_addr_q <= seq_addr;
         ent_data_q <= seq_is_store ? seq_data : '0;
      end else if (evt.cap) begin
         ent_data_q <= rsp_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_valid   <= 1'b0;
         done_is_read <= 1'b0;
         done_data    <= '0;
      end else begin
         done_valid <= trig_take;
         if (trig_take) begin
            done_is_read <= (state_q == ST_RD);
            done_data    <= (state_q == ST_RD) ? ent_data_q : '0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) err_flag <= 1'b0;
      else if (evt.err || net_fwd_valid) err_flag <= 1'b1;
   end

   dcc_rsp_decode u_decode (
      .state (state_q),
      .fire  (rsp_fire),
      .kind  (rsp_kind),
      .evt   (evt)
   );

   dcc_ack_tracker #(.ACK_W(ACK_W)) u_acks (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (seq_fire),
      .upd        (evt.upd),
      .acks       (rsp_acks),
      .consume    (trig_valid),
      .trig_valid (trig_valid)
   );

   assign req_din = {seq_is_store, seq_addr, seq_len, seq_data};
   assign {req_is_write, req_addr, req_len, req_data} = req_dout;

   dcc_delay_pulse #(.MAX_LAT(MAX_LAT), .LAT(REQ_LAT), .W(REQ_PW)) u_req_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (seq_fire),
      .din   (req_din),
      .pulse (req_valid),
      .dout  (req_dout)
   );

   dcc_delay_pulse #(.MAX_LAT(MAX_LAT), .LAT(RSP_LAT), .W(ADDR_W)) u_unb_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (trig_take),
      .din   (ent_addr_q),
      .pulse (unb_valid),
      .dout  (unb_addr)
   );

endmodule

// File: rtl/dcc_checker.sv
module dcc_checker (
   input logic clk,
   input logic rst_n,
   input logic seq_valid,
   input logic seq_ready,
   input logic rsp_ready,
   input logic trig_valid,
   input logic done_valid,
   input logic req_valid,
   input logic err_flag,
   input logic net_fwd_valid
);

   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (seq_valid && seq_ready) |=> !seq_ready); // R2
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done_valid |-> seq_ready); // R7
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done_valid |=> !done_valid); // R7
   AST_TRIG_FIRST: assert property (@(posedge clk) disable iff (!rst_n) trig_valid |-> !rsp_ready); // R8
   AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n) req_valid |-> !seq_ready); // R10
   AST_FWD_ERR: assert property (@(posedge clk) disable iff (!rst_n) net_fwd_valid |=> err_flag); // R11
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) err_flag |=> err_flag); // R11

endmodule

bind dma_coh_ctrl dcc_checker u_dcc_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .seq_valid     (seq_valid),
   .seq_ready     (seq_ready),
   .rsp_ready     (rsp_ready),
   .trig_valid    (trig_valid),
   .done_valid    (done_valid),
   .req_valid     (req_valid),
   .err_flag      (err_flag),
   .net_fwd_valid (net_fwd_valid)
);

// File: tb/test_dma_coh_ctrl.sv
module test_dma_coh_ctrl;

   localparam int ADDR_W  = 32;
   localparam int LEN_W   = 8;
   localparam int DATA_W  = 64;
   localparam int ID_W    = 4;
   localparam int REQ_ID  = 5;
   localparam int ACK_W   = 8;
   localparam int REQ_LAT = 2;
   localparam int RSP_LAT = 3;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    seq_valid = 1'b0;
   logic                    seq_ready;
   logic                    seq_is_store = 1'b0;
   logic [ADDR_W-1:0]       seq_addr = '0;
   logic [LEN_W-1:0]        seq_len = '0;
   logic [DATA_W-1:0]       seq_data = '0;
   logic                    req_valid;
   logic                    req_is_write;
   logic [ADDR_W-1:0]       req_addr;
   logic [LEN_W-1:0]        req_len;
   logic [DATA_W-1:0]       req_data;
   logic [ID_W-1:0]         req_src;
   logic                    rsp_valid = 1'b0;
   logic                    rsp_ready;
   logic [1:0]              rsp_kind = 2'b00;
   logic signed [ACK_W-1:0] rsp_acks = '0;
   logic [DATA_W-1:0]       rsp_data = '0;
   logic                    unb_valid;
   logic [ADDR_W-1:0]       unb_addr;
   logic                    done_valid;
   logic                    done_is_read;
   logic [DATA_W-1:0]       done_data;
   logic                    net_fwd_valid = 1'b0;
   logic                    err_flag;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   dma_coh_ctrl #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W), .ID_W(ID_W),
      .REQ_ID(REQ_ID), .ACK_W(ACK_W), .MAX_LAT(15),
      .REQ_LAT(REQ_LAT), .RSP_LAT(RSP_LAT)
   ) i_dma_coh_ctrl (.*);

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      seq_valid = 1'b0; rsp_valid = 1'b0; net_fwd_valid = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Accepts a request and checks the outgoing directory request.
   task automatic do_accept(input logic st, input logic [ADDR_W-1:0] a,
                            input logic [LEN_W-1:0] l, input logic [DATA_W-1:0] d);
      seq_valid = 1'b1; seq_is_store = st; seq_addr = a; seq_len = l; seq_data = d;
      chk("R2 seq_ready idle", seq_ready, 1);
      @(posedge clk);
      @(negedge clk);
      seq_valid = 1'b0;
      chk("R2 seq_ready busy", seq_ready, 0);
      chk("R2 req not early", req_valid, 0);
      repeat (REQ_LAT) @(posedge clk);
      @(negedge clk);
      chk("R2 req_valid", req_valid, 1);
      chk(st ? "R3 req_is_write" : "R2 req_is_write", req_is_write, st);
      chk("R2 req_addr", req_addr, a);
      chk("R2 req_len", req_len, l);
      chk("R2 req_src", req_src, REQ_ID);
      if (st) chk("R3 req_data", req_data, d);
      @(negedge clk);
      chk("R2 req one cycle", req_valid, 0);
   endtask

   // Sends one reply; zero=1 means it must empty the counter.
   task automatic send_rsp(input logic [1:0] k, input logic signed [ACK_W-1:0] n,
                           input logic [DATA_W-1:0] d, input logic zero);
      rsp_valid = 1'b1; rsp_kind = k; rsp_acks = n; rsp_data = d;
      chk("R8 rsp_ready before", rsp_ready, 1);
      @(posedge clk);
      @(negedge clk);
      rsp_valid = 1'b0;
      if (zero) begin
         chk("R8 trigger blocks rsp", rsp_ready, 0);
      end else begin
         chk("R4 no trigger", rsp_ready, 1);
         @(negedge clk);
         chk("R4 no completion", done_valid, 0);
         chk("R4 still busy", seq_ready, 0);
      end
   endtask

   task automatic finish_chk(input logic rd, input logic [DATA_W-1:0] d,
                             input logic [ADDR_W-1:0] a, input logic wait_unb);
      chk("R7 done not early", done_valid, 0);
      @(posedge clk);
      @(negedge clk);
      chk("R7 done_valid", done_valid, 1);
      chk("R7 idle at done", seq_ready, 1);
      chk(rd ? "R5 done_is_read" : "R6 done_is_read", done_is_read, rd);
      chk(rd ? "R5 done_data" : "R6 done_data", done_data, d);
      chk("R9 unb not early", unb_valid, 0);
      if (wait_unb) begin
         @(negedge clk);
         chk("R7 done one cycle", done_valid, 0);
         repeat (RSP_LAT - 1) @(posedge clk);
         @(negedge clk);
         chk("R9 unb_valid", unb_valid, 1);
         chk("R9 unb_addr", unb_addr, a);
         @(negedge clk);
         chk("R9 unb one cycle", unb_valid, 0);
      end
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 seq_ready", seq_ready, 1);
      chk("R1 req_valid", req_valid, 0);
      chk("R1 unb_valid", unb_valid, 0);
      chk("R1 done_valid", done_valid, 0);
      chk("R1 err_flag", err_flag, 0);
   endtask

   task automatic t_read_simple();
      do_accept(1'b0, 32'h1000_0040, 8'd64, 64'hDEAD);
      send_rsp(2'b00, 8'sd0, 64'h0123_4567_89AB_CDEF, 1'b1);
      finish_chk(1'b1, 64'h0123_4567_89AB_CDEF, 32'h1000_0040, 1'b1);
   endtask

   task automatic t_read_sharers();
      do_accept(1'b0, 32'h2000_0080, 8'd32, 64'h0);
      send_rsp(2'b00, -8'sd2, 64'hFACE_B00C_0000_0001, 1'b0);
      send_rsp(2'b01, 8'sd1, 64'h0, 1'b0);
      send_rsp(2'b01, 8'sd1, 64'h0, 1'b1);
      finish_chk(1'b1, 64'hFACE_B00C_0000_0001, 32'h2000_0080, 1'b1);
   endtask

   task automatic t_write();
      do_accept(1'b1, 32'h3000_00C0, 8'd16, 64'h5555_AAAA_1234_8765);
      send_rsp(2'b10, -8'sd1, 64'h0, 1'b0);
      send_rsp(2'b01, 8'sd1, 64'h0, 1'b1);
      finish_chk(1'b0, 64'h0, 32'h3000_00C0, 1'b1);
   endtask

   task automatic t_stall();
      do_accept(1'b0, 32'h4000_0000, 8'd8, 64'h0);
      seq_valid = 1'b1; seq_is_store = 1'b1; seq_addr = 32'h4000_0100;
      seq_len = 8'd4; seq_data = 64'h77;
      repeat (3) @(negedge clk);
      chk("R10 stalled seq_ready", seq_ready, 0);
      chk("R10 no second req", req_valid, 0);
      send_rsp(2'b00, 8'sd0, 64'h99, 1'b1);
      finish_chk(1'b1, 64'h99, 32'h4000_0000, 1'b0);
      do_accept(1'b1, 32'h4000_0100, 8'd4, 64'h77);
      send_rsp(2'b10, 8'sd0, 64'h0, 1'b1);
      finish_chk(1'b0, 64'h0, 32'h4000_0100, 1'b1);
   endtask

   task automatic t_fwd();
      do_reset();
      net_fwd_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      net_fwd_valid = 1'b0;
      chk("R11 err set", err_flag, 1);
      repeat (2) @(negedge clk);
      chk("R11 err sticky", err_flag, 1);
   endtask

   task automatic t_illegal();
      do_reset();
      rsp_valid = 1'b1; rsp_kind = 2'b01; rsp_acks = 8'sd0;
      @(posedge clk);
      @(negedge clk);
      rsp_valid = 1'b0;
      chk("R12 rsp in idle err", err_flag, 1);
      @(negedge clk);
      chk("R12 idle no done", done_valid, 0);

      do_reset();
      do_accept(1'b0, 32'h5000_0000, 8'd8, 64'h0);
      rsp_valid = 1'b1; rsp_kind = 2'b11; rsp_acks = 8'sd0;
      @(posedge clk);
      @(negedge clk);
      rsp_valid = 1'b0;
      chk("R12 kind 11 err", err_flag, 1);
      repeat (2) @(negedge clk);
      chk("R12 kind 11 no done", done_valid, 0);
      chk("R12 kind 11 busy", seq_ready, 0);
      send_rsp(2'b00, 8'sd0, 64'hAB, 1'b1);
      finish_chk(1'b1, 64'hAB, 32'h5000_0000, 1'b1);

      do_reset();
      do_accept(1'b1, 32'h6000_0000, 8'd8, 64'h1);
      rsp_valid = 1'b1; rsp_kind = 2'b00; rsp_acks = 8'sd0; rsp_data = 64'hEE;
      @(posedge clk);
      @(negedge clk);
      rsp_valid = 1'b0;
      chk("R12 data in write err", err_flag, 1);
      repeat (2) @(negedge clk);
      chk("R12 data in write no done", done_valid, 0);
      send_rsp(2'b10, 8'sd0, 64'h0, 1'b1);
      finish_chk(1'b0, 64'h0, 32'h6000_0000, 1'b1);

      do_reset();
      do_accept(1'b0, 32'h7000_0000, 8'd8, 64'h0);
      rsp_valid = 1'b1; rsp_kind = 2'b10; rsp_acks = 8'sd0;
      @(posedge clk);
      @(negedge clk);
      rsp_valid = 1'b0;
      chk("R12 wdone in read err", err_flag, 1);
      repeat (2) @(negedge clk);
      chk("R12 wdone in read no done", done_valid, 0);
      send_rsp(2'b00, 8'sd0, 64'hCD, 1'b1);
      finish_chk(1'b1, 64'hCD, 32'h7000_0000, 1'b1);
   endtask

   initial begin
      t_reset();
      t_read_simple();
      t_read_sharers();
      t_write();
      t_stall();
      t_fwd();
      t_illegal();
      repeat (2) @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule